// File: doc/BRIEF.md
# Debug Trap Unit

This unit sits beside the retirement stage of an in-order CPU core and decides when a debug exception must be raised. On every retirement it looks at the retiring instruction's address and opcode, at whether that instruction is the two-byte software interrupt form, and at the result of the core's I/O privilege check. It also sees every data access the instruction makes, and the trap flag as it stands after the instruction. From these it raises at most one exception request per retirement and tags it with a vector number: 1 for debug events and 3 for the software breakpoint.

Four address comparators are programmed through a small register write port, and the same state can be read back through a read port. Each comparator watches either instruction fetch addresses or data accesses, as chosen by a two-bit kind field in the control register. Debug causes are recorded in a sticky status register, which software clears by writing zeros. Single-stepping is tracked from the trap flag, so the trap falls one instruction after the flag is set. Decode beyond spotting the breakpoint forms, privilege handling, stack frames and the handler itself stay in the core.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset the control and status registers read 0, no request is raised, and no retirement or data access raises a vector-1 request until the control register enables a comparator.
- R2: Control register layout: enable of comparator i at bit i (i = 0..3), kind of comparator i at bits 16+2i+1:16+2i; the unused bits read back as 0. Kind 00 matches a retirement whose address equals the comparator address.
- R3: Kind 01 matches data writes only, kind 11 matches data reads and writes, and kind 10 never matches. A data match is reported as a trap (exc_fault = 0) on the next retirement, with status bit i set.
- R4: An instruction-address match is reported as a fault (exc_fault = 1, vector 1) with only the matching comparator bits added to status. The instruction counts as not executed: the single-step arming is left unchanged and pending data matches are dropped.
- R5: Retiring opcode 0xCC raises a vector-3 request whatever the I/O privilege check result.
- R6: The two-byte software interrupt (ret_is_intn = 1) with immediate 3 raises vector 3 only when ret_iopl_fail = 0. With ret_iopl_fail = 1, or with any other immediate, no request is raised.
- R7: A retirement raises a vector-1 single-step trap, setting status bit 14, when the trap flag (tf_in) was 1 at the previous retirement. The instruction that sets the flag does not trap itself.
- R8: Debug causes met on one retirement, whether data matches or single-step, produce one vector-1 request with all their status bits set together.
- R9: A software breakpoint (R5, R6) takes priority over single-step and data matches on the same retirement. Those other causes then leave the status register unchanged. An instruction-address fault (R4) takes priority over the software breakpoint.
- R10: Status bits stay set until a status write. A write ANDs the status register with the written data, so a 0 clears a bit and a 1 keeps it. Only bits 0..3 and 14 exist.
- R11: exc_req is a one-cycle pulse in the cycle after the retirement that caused it. exc_vec is 1 or 3 while exc_req is high and 0 otherwise.
- R12: The register select codes are 0..3 for the comparator addresses, 4 for control and 5 for status. Codes 6 and 7 read as 0 and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_addr | input | AW | Address of the retiring instruction |
| ret_opcode | input | 8 | First opcode byte of the retiring instruction |
| ret_is_intn | input | 1 | Retiring instruction is the two-byte software interrupt |
| ret_imm | input | 8 | Immediate of the two-byte software interrupt |
| ret_iopl_fail | input | 1 | I/O privilege check failed for this instruction |
| tf_in | input | 1 | Trap flag (flags bit 8) after this instruction |
| da_valid | input | 1 | A data access occurs this cycle |
| da_addr | input | AW | Data access address |
| da_write | input | 1 | 1 = write access, 0 = read access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 3 | Register select for read |
| reg_rd_data | output | 32 | Read data (combinational) |
| exc_req | output | 1 | Exception request pulse |
| exc_vec | output | 8 | Exception vector number |
| exc_fault | output | 1 | 1 = fault (instruction not executed), 0 = trap |

## Verification
The assertions assume that ret_valid is high for exactly one cycle per retiring instruction. They also assume that every data access of an instruction is presented no later than that instruction's retirement cycle, and that tf_in carries the flag value after the instruction. The bench drives each retirement and each data access as a separate one-cycle strobe at the falling edge and holds all strobes low during reset. It also leaves at least one idle cycle between events, so the one-cycle request pulse and the sticky status bits can each be seen on their own. Each sweep reprograms the control register and clears status before it starts, so no pending match carries over from one case into the next.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

  localparam int unsigned REG_W         = 32;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned CTRL_KIND_LSB = 16;
  localparam int unsigned STEP_BIT      = 14;

  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  localparam logic [7:0] VEC_DEBUG = 8'd1;
  localparam logic [7:0] VEC_BRKPT = 8'd3;
  localparam logic [7:0] OPC_BRKPT = 8'hCC;
  localparam logic [7:0] IMM_BRKPT = 8'd3;

  typedef enum logic [1:0] {
    BPK_EXEC = 2'b00,
    BPK_WR   = 2'b01,
    BPK_RSVD = 2'b10,
    BPK_RDWR = 2'b11
  } bp_kind_e;

  function automatic logic kind_hits_exec(input bp_kind_e k);
    return k == BPK_EXEC;
  endfunction

  function automatic logic kind_hits_data(input bp_kind_e k, input logic is_wr);
    return (k == BPK_RDWR) || ((k == BPK_WR) && is_wr);
  endfunction

  function automatic bp_kind_e ctrl_kind(input logic [REG_W-1:0] c, input int unsigned idx);
    return bp_kind_e'(c[CTRL_KIND_LSB + 2*idx +: 2]);
  endfunction

  function automatic logic is_sw_brkpt(input logic [7:0] opc, input logic intn,
                                       input logic [7:0] imm, input logic iopl_fail);
    return (opc == OPC_BRKPT) || (intn && (imm == IMM_BRKPT) && !iopl_fail);
  endfunction

  function automatic logic [REG_W-1:0] ctrl_mask(input int unsigned nbp);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nbp; i++) begin
      m[i] = 1'b1;
      m[CTRL_KIND_LSB + 2*i +: 2] = 2'b11;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] stat_mask(input int unsigned nbp);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nbp; i++) m[i] = 1'b1;
    m[STEP_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_trap_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          en,
  input  bp_kind_e      kind,
  input  logic [AW-1:0] bp_addr,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic          da_valid,
  input  logic [AW-1:0] da_addr,
  input  logic          da_write,
  output logic          exec_hit,
  output logic          data_hit
);

  logic ret_eq;
  logic da_eq;

  assign ret_eq   = (ret_addr == bp_addr);
  assign da_eq    = (da_addr == bp_addr);
  assign exec_hit = en && ret_valid && ret_eq && kind_hits_exec(kind);
  assign data_hit = en && da_valid && da_eq && kind_hits_data(kind, da_write);

endmodule

// File: rtl/dbg_step_track.sv
module dbg_step_track (
  input  logic clk,
  input  logic rst_n,
  input  logic completed,
  input  logic tf_in,
  output logic armed
);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (completed) armed_q <= tf_in;
  end

  assign armed = armed_q;

endmodule

// File: rtl/dbg_data_pend.sv
module dbg_data_pend #(
  parameter int unsigned NBP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NBP-1:0] cur_hits,
  input  logic           retire,
  input  logic [NBP-1:0] en_mask,
  output logic [NBP-1:0] hits_all
);

  logic [NBP-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= '0;
    else if (retire) pend_q <= '0;
    else             pend_q <= pend_q | cur_hits;
  end

  assign hits_all = (pend_q | cur_hits) & en_mask;

endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
  import dbg_trap_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned NBP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [AW-1:0]    ret_addr,
  input  logic [7:0]       ret_opcode,
  input  logic             ret_is_intn,
  input  logic [7:0]       ret_imm,
  input  logic             ret_iopl_fail,
  input  logic             tf_in,
  input  logic             da_valid,
  input  logic [AW-1:0]    da_addr,
  input  logic             da_write,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_wr_sel,
  input  logic [31:0]      reg_wr_data,
  input  logic [2:0]       reg_rd_sel,
  output logic [31:0]      reg_rd_data,
  output logic             exc_req,
  output logic [7:0]       exc_vec,
  output logic             exc_fault
);

  localparam logic [REG_W-1:0] CTRL_MASK = ctrl_mask(NBP);
  localparam logic [REG_W-1:0] STAT_MASK = stat_mask(NBP);

  // ---------------- register file ----------------
  logic [AW-1:0]    bp_addr_q [NBP];
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] status_n;
  logic [REG_W-1:0] stat_set;
  logic [NBP-1:0]   en_mask;
  logic             wr_ctrl;
  logic             wr_stat;

  assign wr_ctrl = reg_wr_en && (reg_wr_sel == SEL_CTRL);
  assign wr_stat = reg_wr_en && (reg_wr_sel == SEL_STAT);
  assign en_mask = ctrl_q[NBP-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBP; i++) bp_addr_q[i] <= '0;
    end else if (reg_wr_en) begin
      for (int i = 0; i < NBP; i++)
        if (reg_wr_sel == SEL_W'(i)) bp_addr_q[i] <= reg_wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wr_data & CTRL_MASK;
  end

  // ---------------- comparators ----------------
  logic [NBP-1:0] exec_hits;
  logic [NBP-1:0] data_cur;
  logic [NBP-1:0] data_all;

  for (genvar g = 0; g < NBP; g++) begin : g_bp
    dbg_bp_match #(.AW(AW)) u_match (
      .en        (ctrl_q[g]),
      .kind      (ctrl_kind(ctrl_q, g)),
      .bp_addr   (bp_addr_q[g]),
      .ret_valid (ret_valid),
      .ret_addr  (ret_addr),
      .da_valid  (da_valid),
      .da_addr   (da_addr),
      .da_write  (da_write),
      .exec_hit  (exec_hits[g]),
      .data_hit  (data_cur[g])
    );
  end

  dbg_data_pend #(.NBP(NBP)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_hits (data_cur),
    .retire   (ret_valid),
    .en_mask  (en_mask),
    .hits_all (data_all)
  );

  // ---------------- event wires ----------------
  logic           step_armed;
  logic           evt_step;
  logic           evt_exec_any;
  logic           evt_swbp;
  logic [NBP-1:0] evt_data_hits;
  logic           win_fault;
  logic           win_swbp;
  logic           win_trap;
  logic           completed;

  assign evt_exec_any  = |exec_hits;
  assign evt_step      = ret_valid && step_armed;
  assign evt_swbp      = ret_valid && is_sw_brkpt(ret_opcode, ret_is_intn, ret_imm, ret_iopl_fail);
  assign evt_data_hits = ret_valid ? data_all : '0;

  assign win_fault = evt_exec_any;
  assign win_swbp  = !win_fault && evt_swbp;
  assign win_trap  = !win_fault && !evt_swbp && (evt_step || (|evt_data_hits));
  assign completed = ret_valid && !win_fault;

  dbg_step_track u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .completed (completed),
    .tf_in     (tf_in),
    .armed     (step_armed)
  );

  // ---------------- status update ----------------
  always_comb begin
    stat_set = '0;
    if (win_fault) begin
      stat_set[NBP-1:0] = exec_hits;
    end else if (win_trap) begin
      stat_set[NBP-1:0] = evt_data_hits;
      stat_set[STEP_BIT] = evt_step;
    end
    status_n = ((wr_stat ? (status_q & reg_wr_data) : status_q) | stat_set) & STAT_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_n;
  end

  // ---------------- request output ----------------
  logic       req_q;
  logic [7:0] vec_q;
  logic       fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      vec_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      req_q   <= win_fault || win_swbp || win_trap;
      vec_q   <= win_swbp ? VEC_BRKPT : ((win_fault || win_trap) ? VEC_DEBUG : 8'd0);
      fault_q <= win_fault;
    end
  end

  assign exc_req   = req_q;
  assign exc_vec   = vec_q;
  assign exc_fault = fault_q;

  // ---------------- read port ----------------
  always_comb begin
    reg_rd_data = '0;
    if (reg_rd_sel == SEL_CTRL)      reg_rd_data = ctrl_q;
    else if (reg_rd_sel == SEL_STAT) reg_rd_data = status_q;
    else begin
      for (int i = 0; i < NBP; i++)
        if (reg_rd_sel == SEL_W'(i)) reg_rd_data = REG_W'(bp_addr_q[i]);
    end
  end

endmodule

// File: rtl/dbg_trap_unit_chk.sv
module dbg_trap_unit_chk
  import dbg_trap_pkg::*;
#(
  parameter int unsigned NBP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic [7:0]       ret_opcode,
  input logic             reg_wr_en,
  input logic [2:0]       reg_wr_sel,
  input logic             exc_req,
  input logic [7:0]       exc_vec,
  input logic             exc_fault,
  input logic             evt_step,
  input logic             evt_exec_any,
  input logic             win_swbp,
  input logic [REG_W-1:0] ctrl_q,
  input logic [REG_W-1:0] status_q
);

  assert_vec_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vec == VEC_DEBUG || exc_vec == VEC_BRKPT));

  assert_req_after_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(ret_valid));

  assert_fault_is_debug_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fault |-> (exc_req && exc_vec == VEC_DEBUG));

  assert_step_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && evt_step && !evt_exec_any && !win_swbp)
      |=> (exc_req && exc_vec == VEC_DEBUG && !exc_fault && status_q[STEP_BIT]));

  assert_int3_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_opcode == OPC_BRKPT && !evt_exec_any)
      |=> (exc_req && exc_vec == VEC_BRKPT));

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ctrl_q[NBP-1:0] == '0 && !evt_step && !win_swbp) |=> !exc_req);

  assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_wr_sel == SEL_STAT)
      |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

bind dbg_trap_unit dbg_trap_unit_chk #(.NBP(NBP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ret_valid    (ret_valid),
  .ret_opcode   (ret_opcode),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_sel   (reg_wr_sel),
  .exc_req      (exc_req),
  .exc_vec      (exc_vec),
  .exc_fault    (exc_fault),
  .evt_step     (evt_step),
  .evt_exec_any (evt_exec_any),
  .win_swbp     (win_swbp),
  .ctrl_q       (ctrl_q),
  .status_q     (status_q)
);

// File: tb/dbg_trap_unit_bench.sv
`timescale 1ns/1ps
module dbg_trap_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic [31:0] ret_addr = '0;
  logic [7:0]  ret_opcode = '0;
  logic        ret_is_intn = 1'b0;
  logic [7:0]  ret_imm = '0;
  logic        ret_iopl_fail = 1'b0;
  logic        tf_in = 1'b0;
  logic        da_valid = 1'b0;
  logic [31:0] da_addr = '0;
  logic        da_write = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_sel = '0;
  logic [31:0] reg_rd_data;
  logic        exc_req;
  logic [7:0]  exc_vec;
  logic        exc_fault;

  int n_chk = 0;
  int n_fail = 0;
  logic       o_req;
  logic [7:0] o_vec;
  logic       o_fault;

  dbg_trap_unit u_dbg_trap_unit (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_rd_sel = sel;
    #1;
    d = reg_rd_data;
  endtask

  task automatic retire(input logic [31:0] a, input logic [7:0] op, input logic intn,
                        input logic [7:0] imm, input logic fail, input logic tf);
    @(negedge clk);
    ret_valid = 1'b1; ret_addr = a; ret_opcode = op; ret_is_intn = intn;
    ret_imm = imm; ret_iopl_fail = fail; tf_in = tf;
    @(negedge clk);
    ret_valid = 1'b0;
    o_req = exc_req; o_vec = exc_vec; o_fault = exc_fault;
  endtask

  task automatic data_acc(input logic [31:0] a, input logic w);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; da_write = w;
    @(negedge clk);
    da_valid = 1'b0;
  endtask

  task automatic expect_req(input string tag, input logic req, input logic [7:0] vec,
                            input logic fault);
    chk({tag, " req"}, {31'd0, o_req}, {31'd0, req});
    chk({tag, " vec"}, {24'd0, o_vec}, {24'd0, vec});
    chk({tag, " fault"}, {31'd0, o_fault}, {31'd0, fault});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(3'd4, d); chk("R1 ctrl after reset", d, 32'h0);
    rd(3'd5, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 no request after reset", {31'd0, exc_req}, 32'h0);
    data_acc(32'h0, 1'b1);
    retire(32'h0, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R1 disabled address 0", 1'b0, 8'd0, 1'b0);

    // R2, R12: register layout and select codes
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R2 ctrl implemented bits", d, 32'h00FF_000F);
    wr(3'd4, 32'h0);
    for (int i = 0; i < 4; i++) wr(3'(i), 32'h1000 + 32'(i) * 32'h10);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d); chk("R12 address readback", d, 32'h1000 + 32'(i) * 32'h10);
    end
    wr(3'd6, 32'hDEAD_BEEF);
    wr(3'd7, 32'hDEAD_BEEF);
    rd(3'd6, d); chk("R12 sel 6 reads zero", d, 32'h0);
    rd(3'd7, d); chk("R12 sel 7 reads zero", d, 32'h0);
    rd(3'd4, d); chk("R12 unused sel write ignored", d, 32'h0);

    // R2, R3, R4: sweep comparator x kind x enable x access type
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        for (int en = 0; en < 2; en++) begin
          for (int acc = 0; acc < 3; acc++) begin
            logic hit;
            logic [31:0] ctrl;
            logic [31:0] ba;
            ba = 32'h1000 + 32'(i) * 32'h10;
            ctrl = (en != 0) ? ((32'd1 << i) | (32'(k) << (16 + 2 * i))) : (32'(k) << (16 + 2 * i));
            wr(3'd4, ctrl);
            wr(3'd5, 32'h0);
            hit = (en != 0) && ((acc == 0 && k == 0) || (acc == 2 && (k == 1 || k == 3)) ||
                                (acc == 1 && k == 3));
            if (acc == 0) begin
              retire(ba, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
              expect_req("R2 exec sweep", hit, hit ? 8'd1 : 8'd0, hit);
            end else begin
              data_acc(ba, acc == 2);
              retire(32'h5000, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
              expect_req("R3 data sweep", hit, hit ? 8'd1 : 8'd0, 1'b0);
            end
            rd(3'd5, d); chk("R3 sweep status", d, hit ? (32'd1 << i) : 32'h0);
          end
        end
      end
    end

    // R7: single-step one instruction late
    wr(3'd4, 32'h0); wr(3'd5, 32'h0);
    retire(32'h2000, 8'h90, 1'b0, 8'h0, 1'b0, 1'b1);
    expect_req("R7 setter does not trap", 1'b0, 8'd0, 1'b0);
    retire(32'h2001, 8'h90, 1'b0, 8'h0, 1'b0, 1'b1);
    expect_req("R7 next instruction traps", 1'b1, 8'd1, 1'b0);
    rd(3'd5, d); chk("R7 status step bit", d, 32'h4000);
    @(negedge clk);
    chk("R11 pulse is one cycle", {31'd0, exc_req}, 32'h0);
    chk("R11 vec zero when idle", {24'd0, exc_vec}, 32'h0);
    retire(32'h2002, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R7 clearing instruction traps", 1'b1, 8'd1, 1'b0);
    retire(32'h2003, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R7 flag off no trap", 1'b0, 8'd0, 1'b0);

    // R4: fault keeps arming, drops pending data
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0000_0003 | (32'h1 << 18));
    retire(32'h2010, 8'h90, 1'b0, 8'h0, 1'b0, 1'b1);
    expect_req("R4 arming step", 1'b0, 8'd0, 1'b0);
    data_acc(32'h1010, 1'b1);
    retire(32'h1000, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R4 exec fault", 1'b1, 8'd1, 1'b1);
    rd(3'd5, d); chk("R4 status exec only", d, 32'h1);
    retire(32'h2014, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R4 step survives fault", 1'b1, 8'd1, 1'b0);
    rd(3'd5, d); chk("R4 pending data dropped", d, 32'h4001);

    // R8: combined causes
    wr(3'd5, 32'h0);
    retire(32'h2018, 8'h90, 1'b0, 8'h0, 1'b0, 1'b1);
    expect_req("R8 arming step", 1'b0, 8'd0, 1'b0);
    data_acc(32'h1010, 1'b1);
    retire(32'h201C, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R8 single request", 1'b1, 8'd1, 1'b0);
    rd(3'd5, d); chk("R8 both status bits", d, 32'h4002);

    // R10: sticky status, AND-write clearing
    retire(32'h2020, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    rd(3'd5, d); chk("R10 status held", d, 32'h4002);
    wr(3'd5, 32'hFFFF_BFFF);
    rd(3'd5, d); chk("R10 write zero clears bit 14", d, 32'h0002);
    wr(3'd5, 32'h0);
    rd(3'd5, d); chk("R10 write zero clears all", d, 32'h0);

    // R9: software breakpoint beats single-step
    retire(32'h2024, 8'h90, 1'b0, 8'h0, 1'b0, 1'b1);
    retire(32'h2028, 8'hCC, 1'b0, 8'h0, 1'b0, 1'b1);
    expect_req("R9 int3 over step", 1'b1, 8'd3, 1'b0);
    rd(3'd5, d); chk("R9 step not recorded", d, 32'h0);
    retire(32'h202C, 8'h90, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R9 step after int3", 1'b1, 8'd1, 1'b0);
    wr(3'd5, 32'h0);
    retire(32'h1000, 8'hCC, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R9 exec fault over int3", 1'b1, 8'd1, 1'b1);
    wr(3'd4, 32'h0); wr(3'd5, 32'h0);

    // R5, R6: software breakpoint forms and privilege
    retire(32'h3000, 8'hCC, 1'b0, 8'h0, 1'b1, 1'b0);
    expect_req("R5 0xCC ignores privilege fail", 1'b1, 8'd3, 1'b0);
    retire(32'h3001, 8'hCC, 1'b0, 8'h0, 1'b0, 1'b0);
    expect_req("R5 0xCC plain", 1'b1, 8'd3, 1'b0);
    retire(32'h3002, 8'hCD, 1'b1, 8'd3, 1'b0, 1'b0);
    expect_req("R6 int n=3 allowed", 1'b1, 8'd3, 1'b0);
    retire(32'h3004, 8'hCD, 1'b1, 8'd3, 1'b1, 1'b0);
    expect_req("R6 int n=3 privilege fail", 1'b0, 8'd0, 1'b0);
    retire(32'h3006, 8'hCD, 1'b1, 8'd4, 1'b0, 1'b0);
    expect_req("R6 int n=4 no request", 1'b0, 8'd0, 1'b0);
    rd(3'd5, d); chk("R6 status untouched", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule